// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block watches one bank of general-purpose input pins (32 by default) and turns activity on them into interrupts. Each pin has three configuration bits. The first picks level or edge sensing. The second picks the active level or edge. The third, for edge-sensed pins, makes the pin fire on both edges. Pins are synchronised and compared with their previous value. Any qualifying event sets a sticky per-pin status bit.

Software reaches the block through a plain valid/write/address/data strobe. The interrupt enables are never written directly: one address sets enables and another clears them, and the mask word reads back inverted (1 = disabled). Status bits are cleared by writing 1 to them. Status bits are recorded whether or not a pin is enabled. The single interrupt output is raised when any enabled pin has a pending status bit, so service software should clear the status ANDed with the enabled pins.

`rst_n` is an asynchronous active-low reset. The system must release it in step with `clk`.

Top module: `gpio_irq_bank`

## Requirements
- R1: A write to address 0 sets the enable of every pin whose data bit is 1, and leaves pins written with 0 unchanged.
- R2: A write to address 1 clears the enable of every pin whose data bit is 1, and leaves pins written with 0 unchanged.
- R3: `bus_rdata` is combinational in `bus_addr`. Address 2 returns the mask, with 1 for a disabled pin and 0 for an enabled one. Addresses 0, 1 and 7 read as zero, and writes to 2 or 7 change nothing.
- R4: A write to address 3 clears each status bit written as 1. Bits written as 0 keep their pending state. Address 3 reads the status word.
- R5: In level mode (type bit 0), a pin sets its status bit on every cycle its synchronised input equals its polarity bit (1 = high, 0 = low). This holds even in the cycle of a clear, because a new event wins over a clear.
- R6: In edge mode (type bit 1) with the any-edge bit 0, a pin fires only on a rising edge when its polarity bit is 1, and only on a falling edge when its polarity bit is 0.
- R7: In edge mode with the any-edge bit 1, a pin fires on both edges whatever its polarity bit.
- R8: Addresses 4 (type), 5 (polarity) and 6 (any-edge) are written as whole words, replacing every pin's setting at once, and read back the stored word.
- R9: `irq_o` is high exactly when some pin has both its status bit and its enable set.
- R10: While reset is held, every pin is disabled (mask reads all ones), and status, type, polarity and any-edge are zero. `irq_o` is low.
- R11: A change on a pin input reaches its status bit on the third rising clock edge after the change: two synchroniser stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw asynchronous pin levels |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt, status AND enable |

## Verification
The bench first holds a level-sensed pin active and clears it, so that it can see the bit come straight back. A design that let the clear win would drop an interrupt that is still being asserted. It counts the edges from a pin change to its status bit and checks the status after the second and third edges. An extra or missing synchroniser stage shows up as a status bit that is late or early. It drives edge-sensed pins with the polarity set both ways and with any-edge set. A design that mixed up the polarity, or that still honoured polarity with any-edge set, would miss the edge it should catch or catch the one it should ignore. Finally, random writes land on the set, clear, status and unmapped addresses, mixed with pin toggles. A write with zero bits that disturbed other pins, or a mask that read back uninverted, would then differ from the bench's model.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_EN_SET = 3'd0,
    REG_EN_CLR = 3'd1,
    REG_MASK   = 3'd2,
    REG_STATUS = 3'd3,
    REG_TYPE   = 3'd4,
    REG_POL    = 3'd5,
    REG_ANY    = 3'd6,
    REG_NONE   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser plus one history stage for edge comparison.
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
// Per-pin event qualification: level or edge, polarity, single or both edges.
module gpio_irq_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] edge_sel_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] both_i,
  output logic [W-1:0] event_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit;
    always_comb begin
      rise = cur_i[i] & ~prev_i[i];
      fall = ~cur_i[i] & prev_i[i];
      if (edge_sel_i[i]) begin
        if (both_i[i])     hit = rise | fall;
        else if (pol_i[i]) hit = rise;
        else               hit = fall;
      end else begin
        hit = (cur_i[i] == pol_i[i]);
      end
    end
    assign event_o[i] = hit;
  end
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
// Enable set/clear, sticky status with write-1-clear, configuration words.
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      event_i,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      edge_sel_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      both_o,
  output logic              irq_o
);
  reg_sel_e     sel;
  logic         wr;
  logic [W-1:0] en_q, en_d, status_q, status_d, clr_mask;
  logic [W-1:0] edge_q, pol_q, both_q;
  logic         en_we, edge_we, pol_we, both_we;

  assign sel = reg_sel_e'(bus_addr);
  assign wr  = bus_valid & bus_write;

  // next state
  always_comb begin
    en_we    = 1'b0;
    en_d     = en_q;
    clr_mask = '0;
    if (wr && sel == REG_EN_SET) begin
      en_we = 1'b1;
      en_d  = en_q | bus_wdata;
    end else if (wr && sel == REG_EN_CLR) begin
      en_we = 1'b1;
      en_d  = en_q & ~bus_wdata;
    end
    if (wr && sel == REG_STATUS) clr_mask = bus_wdata;
    status_d = (status_q & ~clr_mask) | event_i;
    edge_we  = wr && sel == REG_TYPE;
    pol_we   = wr && sel == REG_POL;
    both_we  = wr && sel == REG_ANY;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      status_q <= '0;
      edge_q   <= '0;
      pol_q    <= '0;
      both_q   <= '0;
    end else begin
      status_q <= status_d;
      if (en_we)   en_q   <= en_d;
      if (edge_we) edge_q <= bus_wdata;
      if (pol_we)  pol_q  <= bus_wdata;
      if (both_we) both_q <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    case (sel)
      REG_MASK:   bus_rdata = ~en_q;
      REG_STATUS: bus_rdata = status_q;
      REG_TYPE:   bus_rdata = edge_q;
      REG_POL:    bus_rdata = pol_q;
      REG_ANY:    bus_rdata = both_q;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq_o      = |(status_q & en_q);
  assign en_o       = en_q;
  assign status_o   = status_q;
  assign edge_sel_o = edge_q;
  assign pol_o      = pol_q;
  assign both_o     = both_q;
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o
);
  logic [NPINS-1:0] cur, prev, events;
  logic [NPINS-1:0] en_q, status_q, edge_q, pol_q, both_q;

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .cur_o  (cur),
    .prev_o (prev)
  );

  gpio_irq_detect #(.W(NPINS)) u_detect (
    .cur_i      (cur),
    .prev_i     (prev),
    .edge_sel_i (edge_q),
    .pol_i      (pol_q),
    .both_i     (both_q),
    .event_o    (events)
  );

  gpio_irq_regs #(.W(NPINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .event_i    (events),
    .bus_rdata  (bus_rdata),
    .en_o       (en_q),
    .status_o   (status_q),
    .edge_sel_o (edge_q),
    .pol_o      (pol_q),
    .both_o     (both_q),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk #(
  parameter int unsigned NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [2:0]       bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] status_q,
  input logic [NPINS-1:0] edge_q,
  input logic             irq_o
);
  logic wr_set, wr_clr, wr_stat, wr_type;
  assign wr_set  = bus_valid && bus_write && bus_addr == 3'd0;
  assign wr_clr  = bus_valid && bus_write && bus_addr == 3'd1;
  assign wr_stat = bus_valid && bus_write && bus_addr == 3'd3;
  assign wr_type = bus_valid && bus_write && bus_addr == 3'd4;

  assert_en_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)) &&
               ((en_q & ~$past(bus_wdata)) == ($past(en_q) & ~$past(bus_wdata))));

  assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_q & $past(bus_wdata)) == '0) &&
               ((en_q & ~$past(bus_wdata)) == ($past(en_q) & ~$past(bus_wdata))));

  assert_status_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((status_q & $past(status_q & ~bus_wdata)) == $past(status_q & ~bus_wdata)));

  assert_type_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_type |=> (edge_q == $past(bus_wdata)));

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && bus_wdata == '1) |=> !irq_o);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_q      (en_q),
  .status_q  (status_q),
  .edge_q    (edge_q),
  .irq_o     (irq_o)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
  localparam int N = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] pins;
  logic         bv, bw;
  logic [2:0]   ba;
  logic [N-1:0] wd;
  logic [N-1:0] rd;
  logic         irq;

  gpio_irq_bank #(.NPINS(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_valid(bv), .bus_write(bw),
    .bus_addr(ba), .bus_wdata(wd), .bus_rdata(rd), .irq_o(irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [N-1:0] m_s1, m_s2, m_prev, m_st, m_en, m_ty, m_po, m_an;

  function automatic logic [N-1:0] f_event(logic [N-1:0] c, logic [N-1:0] p,
      logic [N-1:0] ty, logic [N-1:0] po, logic [N-1:0] an);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (ty[i]) r[i] = an[i] ? (c[i] ^ p[i]) : (po[i] ? (c[i] & ~p[i]) : (~c[i] & p[i]));
      else       r[i] = (c[i] == po[i]);
    end
    return r;
  endfunction

  function automatic logic [N-1:0] f_read(logic [2:0] a);
    case (a)
      3'd2: return ~m_en;
      3'd3: return m_st;
      3'd4: return m_ty;
      3'd5: return m_po;
      3'd6: return m_an;
      default: return '0;
    endcase
  endfunction

  function automatic string f_tag(logic [2:0] a);
    case (a)
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4, 3'd5, 3'd6: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [2:0] a);
    bv = 1'b0; ba = a; #1;
    chk(req, rd, f_read(a));
  endtask

  task automatic irq_chk(string req);
    chk(req, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_st & m_en)});
  endtask

  // one clock: drive at negedge, advance model at posedge, return at negedge
  task automatic cyc(logic v, logic [2:0] a, logic [N-1:0] d, logic [N-1:0] p);
    logic [N-1:0] ev, clr, en_n, ty_n, po_n, an_n;
    bv = v; bw = v; ba = a; wd = d; pins = p;
    ev   = f_event(m_s2, m_prev, m_ty, m_po, m_an);
    clr  = (v && a == 3'd3) ? d : '0;
    en_n = m_en; ty_n = m_ty; po_n = m_po; an_n = m_an;
    if (v && a == 3'd0) en_n = m_en | d;
    if (v && a == 3'd1) en_n = m_en & ~d;
    if (v && a == 3'd4) ty_n = d;
    if (v && a == 3'd5) po_n = d;
    if (v && a == 3'd6) an_n = d;
    @(posedge clk);
    m_st = (m_st & ~clr) | ev;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = p;
    m_en = en_n; m_ty = ty_n; m_po = po_n; m_an = an_n;
    @(negedge clk);
    bv = 1'b0; bw = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [N-1:0] p;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pins = '0; bv = 0; bw = 0; ba = 3'd0; wd = '0;
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_en = '0;
    m_ty = '0; m_po = '0; m_an = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    bv = 0; ba = 3'd2; #1; chk("R10", rd, '1);
    ba = 3'd3; #1; chk("R10", rd, '0);
    ba = 3'd4; #1; chk("R10", rd, '0);
    ba = 3'd5; #1; chk("R10", rd, '0);
    ba = 3'd6; #1; chk("R10", rd, '0);
    chk("R10", {{(N-1){1'b0}}, irq}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: default active-low level with pins low sets every status bit
    p = '0;
    repeat (2) cyc(0, 3'd0, '0, p);
    rd_chk("R5", 3'd3);
    chk("R5", rd, '1);
    irq_chk("R9");

    // switch to active-high and clear
    cyc(1, 3'd5, '1, p);
    rd_chk("R8", 3'd5);
    cyc(1, 3'd3, '1, p);
    cyc(0, 3'd0, '0, p);
    rd_chk("R4", 3'd3);
    chk("R4", rd, '0);

    // R1/R2/R3 enable set and clear
    cyc(1, 3'd0, 32'h0000_00F0, p);
    cyc(1, 3'd0, 32'h0000_0001, p);
    rd_chk("R1", 3'd2);
    chk("R3", rd, ~32'h0000_00F1);
    cyc(1, 3'd1, 32'h0000_0010, p);
    rd_chk("R2", 3'd2);
    chk("R2", rd, ~32'h0000_00E1);
    cyc(1, 3'd2, '0, p);  // write to mask address ignored
    rd_chk("R3", 3'd2);
    rd_chk("R3", 3'd0);

    // R11: latency of pin 0 going high
    p = 32'h1;
    cyc(0, 3'd0, '0, p);
    cyc(0, 3'd0, '0, p);
    bv = 0; ba = 3'd3; #1; chk("R11", rd, '0);
    cyc(0, 3'd0, '0, p);
    ba = 3'd3; #1; chk("R11", rd, 32'h1);
    irq_chk("R9");
    chk("R9", {{(N-1){1'b0}}, irq}, 32'h1);

    // R5: clear while the level is held, event wins
    cyc(1, 3'd3, 32'h1, p);
    rd_chk("R5", 3'd3);
    chk("R5", rd, 32'h1);

    // edge modes: low half single edge, high half both edges
    cyc(1, 3'd4, '1, p);
    cyc(1, 3'd6, 32'hFFFF_0000, p);
    cyc(1, 3'd5, 32'h0000_00FF, p);  // bytes 0 rising, 1 falling
    cyc(1, 3'd3, '1, p);
    cyc(0, 3'd0, '0, p);
    rd_chk("R6", 3'd3);
    p = 32'h0003_0303;          // rise on bits 0(held),1,8,9,16,17
    repeat (3) cyc(0, 3'd0, '0, p);
    rd_chk("R6", 3'd3);
    rd_chk("R7", 3'd3);
    cyc(1, 3'd3, '1, p);
    p = 32'h0000_0000;          // falls everywhere set
    repeat (3) cyc(0, 3'd0, '0, p);
    rd_chk("R6", 3'd3);
    rd_chk("R7", 3'd3);
    irq_chk("R9");

    // random traffic
    p = '0;
    for (int n = 0; n < 600; n++) begin
      logic [2:0]   a;
      logic [N-1:0] d;
      a = 3'($urandom_range(0, 7));
      d = $urandom;
      if ($urandom_range(0, 9) == 0) d = '1;
      p = p ^ ($urandom & $urandom & $urandom);
      cyc($urandom_range(0, 1) == 1, a, d, p);
      irq_chk("R9");
      a = 3'($urandom_range(0, 7));
      rd_chk(f_tag(a), a);
    end

    cyc(1, 3'd1, '1, p);
    irq_chk("R9");
    chk("R9", {{(N-1){1'b0}}, irq}, '0);

    done = 1;
    summary();
  end
endmodule